// File: doc/BRIEF.md
# Dual-Channel Complex Accumulator

This block is a two-lane signed datapath for complex arithmetic. One lane handles real data and one handles imaginary data. Each lane has a 20-bit adder/subtractor. It can act as a plain adder on fresh operands or as an accumulator that feeds its own result back in. Both lanes take 16-bit words and produce 16-bit words, and each can deliver one result on every clock.

For each lane, the A operand comes from a selector. The selector picks either the freshly registered input word or the lane's own accumulator. The B operand is either the registered B word, or the lane's A-register word taken from a fixed eight-stage delay line, which lets two streams be time-aligned for butterfly-style work. A shared shift code scales each 20-bit result down to the 16-bit output. A per-lane flag reports when the scaled result cannot be represented.

Top module: `cplx_accum`

## Requirements
- R1: After reset, both outputs read zero and both overflow flags are low.
- R2: Operands are sign-extended from 16 to 20 bits. The 2-bit operation code selects the result: 00 gives A+B, 01 gives A−B, 10 gives B−A and 11 passes A. The result wraps modulo 2^20. A word captured at one rising edge appears in the lane result after the next rising edge.
- R3: When a lane's feedback select is 1, its A operand is that lane's current accumulator instead of the A register.
- R4: A high clear input sets both accumulators to zero at the next edge. Clear wins over any operation on that edge.
- R5: While the A clock enable is low, both A registers hold their value. While the B clock enable is low, both B registers hold their value.
- R6: With a shift code s from 0 to 4, each output is bits [15+s:s] of its lane's 20-bit result. Codes 5 to 7 act as 4.
- R7: A lane's overflow flag is high exactly when the result bits above the output slice are not all equal to the output's top bit. With a shift code of 4 or more, the flag therefore never rises.
- R8: When the delay select is 1, each lane's B operand is the sign-extended A-register word from eight clocks before the word now in the A register. The delay line shifts on every clock.
- R9: A lane whose output enable is low drives zero on its data output. The accumulator and the overflow flag are not affected.
- R10: The two lanes have separate operation codes and feedback selects, and the controls of one lane do not change the other lane's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Clears both accumulators |
| ce_a | input | 1 | Clock enable for both A input registers |
| ce_b | input | 1 | Clock enable for both B input registers |
| a_re | input | 16 | Real-lane A input word |
| b_re | input | 16 | Real-lane B input word |
| a_im | input | 16 | Imaginary-lane A input word |
| b_im | input | 16 | Imaginary-lane B input word |
| op_re | input | 2 | Real-lane operation code |
| op_im | input | 2 | Imaginary-lane operation code |
| fb_re | input | 1 | Real-lane A feedback select |
| fb_im | input | 1 | Imaginary-lane A feedback select |
| dly_b | input | 1 | Takes B from the eight-clock delay line in both lanes |
| shift | input | 3 | Output scaling code |
| oe_re | input | 1 | Real-lane output enable |
| oe_im | input | 1 | Imaginary-lane output enable |
| y_re | output | 16 | Real-lane scaled result |
| y_im | output | 16 | Imaginary-lane scaled result |
| ovf_re | output | 1 | Real-lane overflow flag |
| ovf_im | output | 1 | Imaginary-lane overflow flag |

## Verification
Four behaviours are checked by properties on every cycle:
- a clear leaves a zero output with the flag low;
- feedback with the pass code holds the accumulator;
- the flag stays quiet once the shift code reaches 4;
- at shift 0, an output that does not overflow equals the whole accumulator.

The arithmetic of each operation code, the clock-enable hold and the eight-clock alignment of the delay path can only be shown by the bench's scenarios, which compare against a reference model. The same holds for the independence of the lanes and the zeroed outputs when disabled.

// File: rtl/cplx_accum_pkg.sv
package cplx_accum_pkg;
  typedef enum logic [1:0] {
    OP_SUM   = 2'b00,
    OP_DIFF  = 2'b01,
    OP_RDIFF = 2'b10,
    OP_PASS  = 2'b11
  } op_e;
endpackage

// File: rtl/cax_delay.sv
module cax_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [DEPTH];
  logic [W-1:0] stage_d [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_comb stage_d[i] = din;
      end else begin : g_body
        always_comb stage_d[i] = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_d[i];
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/cax_lane.sv
module cax_lane
  import cplx_accum_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20,
  parameter int DLY   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ce_a,
  input  logic             ce_b,
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  input  logic [1:0]       op,
  input  logic             use_fb,
  input  logic             use_dly,
  output logic [ACC_W-1:0] acc_o
);
  localparam int EXT_W = ACC_W - IN_W;

  logic [IN_W-1:0]  a_q, a_d, b_q, b_d, dly_w;
  logic [ACC_W-1:0] acc_q, acc_d, opa, opb;
  op_e              op_sel;

  cax_delay #(.W(IN_W), .DEPTH(DLY)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (a_q),
    .dout (dly_w)
  );

  always_comb begin
    a_d = ce_a ? a_i : a_q;
    b_d = ce_b ? b_i : b_q;
  end

  always_comb begin
    op_sel = op_e'(op);
    opa = use_fb ? acc_q : {{EXT_W{a_q[IN_W-1]}}, a_q};
    opb = use_dly ? {{EXT_W{dly_w[IN_W-1]}}, dly_w}
                  : {{EXT_W{b_q[IN_W-1]}}, b_q};
    unique case (op_sel)
      OP_SUM:   acc_d = opa + opb;
      OP_DIFF:  acc_d = opa - opb;
      OP_RDIFF: acc_d = opb - opa;
      default:  acc_d = opa;
    endcase
    if (clr) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/cax_scale.sv
module cax_scale #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20,
  parameter int SH_W  = 3
) (
  input  logic [ACC_W-1:0] r,
  input  logic [SH_W-1:0]  sh,
  input  logic             oe,
  output logic [IN_W-1:0]  y,
  output logic             ovf
);
  localparam int EXT_W  = ACC_W - IN_W;
  localparam int MAX_SH = ACC_W - IN_W;

  logic [SH_W-1:0]  s_eff;
  logic [ACC_W-1:0] shifted;
  logic [IN_W-1:0]  slice;

  always_comb begin
    s_eff   = (sh > SH_W'(MAX_SH)) ? SH_W'(MAX_SH) : sh;
    shifted = ACC_W'($signed(r) >>> s_eff);
    slice   = shifted[IN_W-1:0];
    ovf     = shifted[ACC_W-1:IN_W] != {EXT_W{slice[IN_W-1]}};
    y       = oe ? slice : '0;
  end
endmodule

// File: rtl/cplx_accum.sv
module cplx_accum #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20,
  parameter int DLY   = 8,
  parameter int SH_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ce_a,
  input  logic            ce_b,
  input  logic [IN_W-1:0] a_re,
  input  logic [IN_W-1:0] b_re,
  input  logic [IN_W-1:0] a_im,
  input  logic [IN_W-1:0] b_im,
  input  logic [1:0]      op_re,
  input  logic [1:0]      op_im,
  input  logic            fb_re,
  input  logic            fb_im,
  input  logic            dly_b,
  input  logic [SH_W-1:0] shift,
  input  logic            oe_re,
  input  logic            oe_im,
  output logic [IN_W-1:0] y_re,
  output logic [IN_W-1:0] y_im,
  output logic            ovf_re,
  output logic            ovf_im
);
  localparam int LANES = 2;

  logic rst_meta, rst_sync;
  logic [IN_W-1:0]  a_arr [LANES];
  logic [IN_W-1:0]  b_arr [LANES];
  logic [1:0]       op_arr [LANES];
  logic             fb_arr [LANES];
  logic             oe_arr [LANES];
  logic [ACC_W-1:0] acc_q [LANES];
  logic [IN_W-1:0]  y_arr [LANES];
  logic             ovf_arr [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    a_arr[0] = a_re;   a_arr[1] = a_im;
    b_arr[0] = b_re;   b_arr[1] = b_im;
    op_arr[0] = op_re; op_arr[1] = op_im;
    fb_arr[0] = fb_re; fb_arr[1] = fb_im;
    oe_arr[0] = oe_re; oe_arr[1] = oe_im;
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      cax_lane #(.IN_W(IN_W), .ACC_W(ACC_W), .DLY(DLY)) u_lane (
        .clk    (clk),
        .rst_n  (rst_sync),
        .clr    (clr),
        .ce_a   (ce_a),
        .ce_b   (ce_b),
        .a_i    (a_arr[l]),
        .b_i    (b_arr[l]),
        .op     (op_arr[l]),
        .use_fb (fb_arr[l]),
        .use_dly(dly_b),
        .acc_o  (acc_q[l])
      );
      cax_scale #(.IN_W(IN_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_scale (
        .r  (acc_q[l]),
        .sh (shift),
        .oe (oe_arr[l]),
        .y  (y_arr[l]),
        .ovf(ovf_arr[l])
      );
    end
  endgenerate

  assign y_re   = y_arr[0];
  assign y_im   = y_arr[1];
  assign ovf_re = ovf_arr[0];
  assign ovf_im = ovf_arr[1];
endmodule

// File: rtl/cplx_accum_chk.sv
module cplx_accum_chk #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20,
  parameter int SH_W  = 3
) (
  input logic             clk,
  input logic             rst_sync,
  input logic             clr,
  input logic [1:0]       op_re,
  input logic [1:0]       op_im,
  input logic             fb_re,
  input logic             fb_im,
  input logic [SH_W-1:0]  shift,
  input logic             oe_re,
  input logic             oe_im,
  input logic [IN_W-1:0]  y_re,
  input logic [IN_W-1:0]  y_im,
  input logic             ovf_re,
  input logic             ovf_im,
  input logic [ACC_W-1:0] acc_re,
  input logic [ACC_W-1:0] acc_im
);
  localparam int EXT_W = ACC_W - IN_W;

  AST_CLR_FLUSH_RE: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(clr) && oe_re |-> (y_re == '0) && !ovf_re);                            // R4
  AST_CLR_FLUSH_IM: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(clr) && oe_im |-> (y_im == '0) && !ovf_im);                            // R4
  AST_PASS_HOLD_RE: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(fb_re && op_re == 2'b11 && !clr) |-> acc_re == $past(acc_re));         // R3
  AST_PASS_HOLD_IM: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(fb_im && op_im == 2'b11 && !clr) |-> acc_im == $past(acc_im));         // R3
  AST_SHIFT_SAT_RE: assert property (@(posedge clk) disable iff (!rst_sync)
    shift >= 3'd4 |-> !ovf_re);                                                  // R7
  AST_SHIFT_SAT_IM: assert property (@(posedge clk) disable iff (!rst_sync)
    shift >= 3'd4 |-> !ovf_im);                                                  // R7
  AST_OUT_SLICE_RE: assert property (@(posedge clk) disable iff (!rst_sync)
    oe_re && shift == '0 && !ovf_re |-> {{EXT_W{y_re[IN_W-1]}}, y_re} == acc_re); // R6
  AST_OUT_SLICE_IM: assert property (@(posedge clk) disable iff (!rst_sync)
    oe_im && shift == '0 && !ovf_im |-> {{EXT_W{y_im[IN_W-1]}}, y_im} == acc_im); // R6
endmodule

bind cplx_accum cplx_accum_chk #(.IN_W(IN_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_chk (
  .clk(clk), .rst_sync(rst_sync), .clr(clr), .op_re(op_re), .op_im(op_im),
  .fb_re(fb_re), .fb_im(fb_im), .shift(shift), .oe_re(oe_re), .oe_im(oe_im),
  .y_re(y_re), .y_im(y_im), .ovf_re(ovf_re), .ovf_im(ovf_im),
  .acc_re(acc_q[0]), .acc_im(acc_q[1])
);

// File: tb/cplx_accum_tb.sv
module cplx_accum_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic clr, ce_a, ce_b, fb_re, fb_im, dly_b, oe_re, oe_im;
  logic [15:0] a_re, b_re, a_im, b_im;
  logic [1:0]  op_re, op_im;
  logic [2:0]  shift;
  logic [15:0] y_re, y_im;
  logic        ovf_re, ovf_im;

  int vec_cnt = 0;
  int err_cnt = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  cplx_accum u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ce_a(ce_a), .ce_b(ce_b),
    .a_re(a_re), .b_re(b_re), .a_im(a_im), .b_im(b_im),
    .op_re(op_re), .op_im(op_im), .fb_re(fb_re), .fb_im(fb_im),
    .dly_b(dly_b), .shift(shift), .oe_re(oe_re), .oe_im(oe_im),
    .y_re(y_re), .y_im(y_im), .ovf_re(ovf_re), .ovf_im(ovf_im)
  );

  // reference model state, lane 0 = real, lane 1 = imaginary
  logic [15:0] m_a [2];
  logic [15:0] m_b [2];
  logic [19:0] m_acc [2];
  logic [15:0] m_hist [2][8];

  function automatic logic [19:0] ext(input logic [15:0] v);
    return {{4{v[15]}}, v};
  endfunction

  function automatic logic [19:0] alu(input logic [1:0] op, input logic [19:0] a, input logic [19:0] b);
    case (op)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: return b - a;
      default: return a;
    endcase
  endfunction

  function automatic logic [16:0] scale(input logic [19:0] r, input logic [2:0] sh, input logic oe);
    int s;
    logic [15:0] y;
    logic ov;
    s = (sh > 3'd4) ? 4 : int'(sh);
    for (int i = 0; i < 16; i++) y[i] = r[i+s];
    ov = 1'b0;
    for (int j = 15 + s; j < 20; j++) if (r[j] != r[15+s]) ov = 1'b1;
    if (!oe) y = 16'h0;
    return {ov, y};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin
        m_a[l] = '0; m_b[l] = '0; m_acc[l] = '0;
        for (int k = 0; k < 8; k++) m_hist[l][k] = '0;
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        logic [19:0] opa, opb;
        logic [1:0] op;
        logic fb;
        op  = (l == 0) ? op_re : op_im;
        fb  = (l == 0) ? fb_re : fb_im;
        opa = fb ? m_acc[l] : ext(m_a[l]);
        opb = dly_b ? ext(m_hist[l][7]) : ext(m_b[l]);
        m_acc[l] = clr ? 20'h0 : alu(op, opa, opb);
        for (int k = 7; k > 0; k--) m_hist[l][k] = m_hist[l][k-1];
        m_hist[l][0] = m_a[l];
        if (ce_a) m_a[l] = (l == 0) ? a_re : a_im;
        if (ce_b) m_b[l] = (l == 0) ? b_re : b_im;
      end
    end
  end

  task automatic check_outputs();
    logic [16:0] er, ei;
    er = scale(m_acc[0], shift, oe_re);
    ei = scale(m_acc[1], shift, oe_im);
    vec_cnt += 2;
    if ({ovf_re, y_re} !== er) begin
      err_cnt++;
      $display("FAIL %s lane re: got ovf=%b y=%h, expected ovf=%b y=%h", tag, ovf_re, y_re, er[16], er[15:0]);
    end
    if ({ovf_im, y_im} !== ei) begin
      err_cnt++;
      $display("FAIL %s lane im: got ovf=%b y=%h, expected ovf=%b y=%h", tag, ovf_im, y_im, ei[16], ei[15:0]);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle();
    clr = 1'b0; ce_a = 1'b1; ce_b = 1'b1; fb_re = 1'b0; fb_im = 1'b0;
    dly_b = 1'b0; oe_re = 1'b1; oe_im = 1'b1; shift = 3'd0;
    op_re = 2'b00; op_im = 2'b00;
  endtask

  task automatic rnd_data();
    a_re = 16'($urandom); b_re = 16'($urandom);
    a_im = 16'($urandom); b_im = 16'($urandom);
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5eed_0c1a);
    rst_n = 1'b0;
    idle();
    clr = 1'b1; ce_a = 1'b0; ce_b = 1'b0;
    a_re = '0; b_re = '0; a_im = '0; b_im = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    repeat (4) tick();

    // R2: each operation code with fresh operands, including extremes
    idle(); tag = "R2";
    a_re = 16'h7FFF; b_re = 16'h8000; a_im = 16'h8000; b_im = 16'h7FFF;
    for (int o = 0; o < 4; o++) begin
      op_re = 2'(o); op_im = 2'(3 - o);
      tick(); tick();
    end
    for (int n = 0; n < 200; n++) begin
      rnd_data(); op_re = 2'($urandom); op_im = op_re; tick();
    end

    // R3: accumulate with feedback
    idle(); tag = "R3"; clr = 1'b1; tick(); clr = 1'b0;
    fb_re = 1'b1; fb_im = 1'b1; shift = 3'd4;
    for (int n = 0; n < 100; n++) begin
      rnd_data(); op_re = 2'($urandom); op_im = 2'($urandom); tick();
    end

    // R7: growth past 16 bits at each shift code
    idle(); tag = "R7"; clr = 1'b1; tick(); clr = 1'b0;
    fb_re = 1'b1; fb_im = 1'b1;
    b_re = 16'h3000; b_im = 16'hD000; op_re = 2'b00; op_im = 2'b00;
    for (int n = 0; n < 40; n++) begin
      shift = 3'(n % 6); tick();
    end

    // R4: clear with priority over accumulate
    tag = "R4"; shift = 3'd0;
    clr = 1'b1; tick(); tick();
    clr = 1'b0; tick();
    for (int n = 0; n < 60; n++) begin
      rnd_data(); clr = ($urandom % 4) == 0; tick();
    end
    clr = 1'b0;

    // R5: clock enables hold the input registers
    idle(); tag = "R5";
    a_re = 16'h1234; b_re = 16'h0101; a_im = 16'hF00F; b_im = 16'h0202; tick();
    for (int n = 0; n < 60; n++) begin
      ce_a = n[0]; ce_b = n[1]; rnd_data();
      op_re = 2'($urandom); op_im = 2'($urandom); tick();
    end

    // R6: every shift code, including the saturating ones
    idle(); tag = "R6";
    for (int n = 0; n < 80; n++) begin
      rnd_data(); shift = 3'(n % 8); op_re = 2'($urandom); op_im = 2'($urandom);
      tick();
    end

    // R8: B taken from the eight-clock delay line
    idle(); tag = "R8"; dly_b = 1'b1;
    for (int n = 0; n < 40; n++) begin
      a_re = 16'(n * 16'h0111); a_im = 16'(16'hFFFF - n);
      op_re = 2'b00; op_im = 2'b10; tick();
    end
    for (int n = 0; n < 60; n++) begin
      rnd_data(); ce_a = $urandom % 2; op_re = 2'($urandom); op_im = 2'($urandom); tick();
    end

    // R9: output enable low zeroes data only
    idle(); tag = "R9";
    for (int n = 0; n < 60; n++) begin
      rnd_data(); oe_re = n[0]; oe_im = n[1]; fb_re = n[2]; fb_im = n[2];
      shift = 3'(n % 3); tick();
    end

    // R10: fully random, lanes controlled independently
    idle(); tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      rnd_data();
      clr = ($urandom % 16) == 0; ce_a = ($urandom % 5) != 0; ce_b = ($urandom % 5) != 0;
      op_re = 2'($urandom); op_im = 2'($urandom);
      fb_re = $urandom % 2; fb_im = $urandom % 2; dly_b = ($urandom % 3) == 0;
      shift = 3'($urandom); oe_re = ($urandom % 6) != 0; oe_im = ($urandom % 6) != 0;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: run did not complete, got timeout, expected end of stimulus");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule